// File: doc/BRIEF.md
# Stereo Serial Audio Shift Engine

This block moves audio samples between parallel word queues and a three-wire stereo serial bus: a bit clock, a word-select line and one data line in each direction. On the transmit side it takes one word per channel slot from an outside queue through a pop handshake and shifts the word out MSB first. On the receive side it collects the incoming bits of each slot back into a word and hands the word to an outside queue with a one-cycle push strobe.

The engine either drives the bit clock and word select itself (master), toggling the bit clock once per pulse of an outside bit-clock enable, or follows both lines from an outside codec (slave) through a short synchronizer. Word width, framing, mono capture, muting and the master/slave choice are plain level inputs. They can change at runtime while the engine is disabled. The block also reports which channel the current transmit word belongs to, whether the transmit path is busy, and a pulse when a word was needed but the queue was empty.

Top module: `i2s_engine`

## Requirements
- R1: While `en` is low, the bit clock and word-select outputs and `sd_out` stay low, and no pop, push or underflow occurs.
- R2: `tx_en` and `rx_en` gate the two directions independently. With `tx_en` low there are no pops or underflows and `sd_out` stays low. With `rx_en` low there are no pushes.
- R3: While `mute` is high, `sd_out` is low on every bit, and queued words are still consumed.
- R4: `word_sel` sets the word width: 0 = 8, 1 = 16, 2 = 24, 3 = 32 bits. Words sit right-aligned in `tx_data`/`rx_data`. Transmit bits above the width are ignored. The remaining bits of each 32-bit slot are sent as zeros. Received bits beyond the width are dropped, and the upper bits of `rx_data` read zero.
- R5: Data goes MSB first. With `msb_just` = 0 the MSB appears on the second bit clock of a slot. With `msb_just` = 1 it appears on the first. Word select is low for the left slot and high for the right slot.
- R6: With `mono` high, only words from right-channel slots are pushed.
- R7: In master mode (`slave` = 0), `bclk_oe` is high. The bit clock toggles once per `bclk_tick`, and each word-select level lasts 32 bit clocks, starting low after enable. In slave mode `bclk_oe` is low and the engine frames its data on `bclk_in`/`ws_in`.
- R8: After each slot load, `tx_right` shows the channel of that slot (1 = right).
- R9: `tx_busy` goes high when a word is loaded from the queue. It returns low at the first slot boundary where the queue has no word.
- R10: At a slot boundary with an empty queue, `tx_underflow` pulses for one cycle and the slot is sent as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global engine enable |
| tx_en | input | 1 | Transmit path enable |
| rx_en | input | 1 | Receive path enable |
| mute | input | 1 | Send zeros instead of data |
| word_sel | input | 2 | Word width code |
| msb_just | input | 1 | 0 = standard delayed framing, 1 = MSB-justified |
| mono | input | 1 | Capture right-channel slots only |
| slave | input | 1 | 1 = follow external bit clock and word select |
| bclk_tick | input | 1 | Half-bit enable for the master bit clock |
| bclk_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word select (slave) |
| sd_in | input | 1 | Serial receive data |
| bclk_out | output | 1 | Generated bit clock (master) |
| ws_out | output | 1 | Generated word select (master) |
| bclk_oe | output | 1 | Pad enable for bit clock and word select |
| sd_out | output | 1 | Serial transmit data |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | MAX_W | Head word of the transmit queue |
| tx_pop | output | 1 | Takes the head word this cycle |
| tx_underflow | output | 1 | Word needed while the queue was empty |
| rx_push | output | 1 | `rx_data` holds a new word |
| rx_data | output | MAX_W | Received word, right-aligned |
| tx_right | output | 1 | Channel of the current transmit slot |
| tx_busy | output | 1 | Transmit path is shifting queued data |

## Verification
The transmit line is looped back to the receive line, so each word is checked end to end. The test words have bits set above the selected width, which shows whether masking and zero fill work. Patterns with only the MSB set (0x80, 0x8000_0000) and sign-flipped values show the framing offset and whether a 32-bit word's LSB carries across into the next slot in standard framing. A separate bus monitor records the bit-clock position of the first high data bit and the slot length, and the two framing modes must differ there by exactly one bit. Separate runs cover mono, mute, each direction disabled, a draining queue and a slave run on an external clock.

// File: rtl/i2s_eng_pkg.sv
package i2s_eng_pkg;

   typedef enum logic [1:0] {
      WW_8  = 2'd0,
      WW_16 = 2'd1,
      WW_24 = 2'd2,
      WW_32 = 2'd3
   } word_w_e;

   // Bus timing events derived from either clock source
   typedef struct packed {
      logic fall;        // bit clock falling: launch point
      logic rise;        // bit clock rising: sample point
      logic slot_start;  // falling edge on which word select changed
      logic ws;          // word-select level valid at a fall
      logic sd;          // serial input aligned to the clock source
   } bus_evt_t;

   function automatic int unsigned width_bits(input word_w_e code);
      return 8 * (int'(code) + 1);
   endfunction

endpackage

// File: rtl/i2s_eng_clk.sv
module i2s_eng_clk
   import i2s_eng_pkg::*;
#(
   parameter int MAX_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     slave,
   input  logic     tick,
   input  logic     bclk_in,
   input  logic     ws_in,
   input  logic     sd_in,
   output logic     bclk_out,
   output logic     ws_out,
   output bus_evt_t evt
);

   localparam int CW = $clog2(MAX_W) + 1;

   logic [SYNC_STAGES-1:0][2:0] sync_q;
   logic [2:0]                  s_now;
   logic                        s_b_last;
   logic                        bclk_q, wsm_q, ws_prev;
   logic [CW-1:0]               cnt_q, cnt_nxt;
   logic                        m_tick, m_rise, m_fall, s_rise, s_fall, ws_new;

   // slave inputs: bit clock, word select and data through one shared chain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q   <= '0;
         s_b_last <= 1'b0;
      end else begin
         sync_q   <= {sync_q[SYNC_STAGES-2:0], {bclk_in, ws_in, sd_in}};
         s_b_last <= sync_q[SYNC_STAGES-1][2];
      end
   end
   assign s_now  = sync_q[SYNC_STAGES-1];
   assign s_rise = en & slave &  s_now[2] & ~s_b_last;
   assign s_fall = en & slave & ~s_now[2] &  s_b_last;

   // master generator
   assign m_tick  = en & ~slave & tick;
   assign m_rise  = m_tick & ~bclk_q;
   assign m_fall  = m_tick &  bclk_q;
   assign cnt_nxt = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         wsm_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (!en || slave) begin
         bclk_q <= 1'b0;
         wsm_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (m_tick) begin
         bclk_q <= ~bclk_q;
         if (bclk_q) begin
            cnt_q <= cnt_nxt;
            wsm_q <= cnt_nxt[CW-1];
         end
      end
   end

   assign ws_new = slave ? s_now[1] : cnt_nxt[CW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ws_prev <= 1'b0;
      else if (!en)      ws_prev <= 1'b0;
      else if (evt.fall) ws_prev <= ws_new;
   end

   assign evt.fall       = m_fall | s_fall;
   assign evt.rise       = m_rise | s_rise;
   assign evt.slot_start = evt.fall & (ws_new != ws_prev);
   assign evt.ws         = ws_new;
   assign evt.sd         = slave ? s_now[0] : sd_in;

   assign bclk_out = bclk_q;
   assign ws_out   = wsm_q;

   // R1
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!bclk_out && !ws_out));

   // R7
   master_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_fall |=> !bclk_out);

endmodule

// File: rtl/i2s_eng_tx.sv
module i2s_eng_tx
   import i2s_eng_pkg::*;
#(
   parameter int MAX_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             fall,
   input  logic             slot_start,
   input  logic             ws,
   input  logic             mute,
   input  logic             just,
   input  logic [1:0]       wsel,
   input  logic             tx_valid,
   input  logic [MAX_W-1:0] tx_data,
   output logic             tx_pop,
   output logic             tx_underflow,
   output logic             sd_out,
   output logic             tx_right,
   output logic             tx_busy
);

   int unsigned      wbits;
   logic [MAX_W-1:0] wmask, load_word, sh_q;
   logic             load, sd_q, right_q, busy_q;

   assign wbits     = width_bits(word_w_e'(wsel));
   assign wmask     = ~({MAX_W{1'b1}} << wbits);
   assign load_word = tx_valid ? ((tx_data & wmask) << (MAX_W - wbits)) : '0;

   assign load         = run & slot_start;
   assign tx_pop       = load &  tx_valid;
   assign tx_underflow = load & ~tx_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         sd_q    <= 1'b0;
         right_q <= 1'b0;
         busy_q  <= 1'b0;
      end else if (!run) begin
         sh_q    <= '0;
         sd_q    <= 1'b0;
         right_q <= 1'b0;
         busy_q  <= 1'b0;
      end else if (fall) begin
         if (slot_start) begin
            right_q <= ws;
            busy_q  <= tx_valid;
            if (just) begin
               sd_q <= ~mute & load_word[MAX_W-1];
               sh_q <= load_word << 1;
            end else begin
               // one-bit delay: the old word's last bit goes out here
               sd_q <= ~mute & sh_q[MAX_W-1];
               sh_q <= load_word;
            end
         end else begin
            sd_q <= ~mute & sh_q[MAX_W-1];
            sh_q <= sh_q << 1;
         end
      end
   end

   assign sd_out   = sd_q;
   assign tx_right = right_q;
   assign tx_busy  = busy_q;

   // R3
   mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mute && fall) |=> !sd_out);

   // R9
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> tx_busy);

   // R10
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underflow |=> !tx_busy);

endmodule

// File: rtl/i2s_eng_rx.sv
module i2s_eng_rx
   import i2s_eng_pkg::*;
#(
   parameter int MAX_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  bus_evt_t         evt,
   input  logic             just,
   input  logic             mono,
   input  logic [1:0]       wsel,
   output logic             rx_push,
   output logic [MAX_W-1:0] rx_data
);

   localparam int PW = $clog2(MAX_W) + 2;

   logic [PW-1:0]    rpos_q, rcnt_q, dly, wlen;
   logic [MAX_W-1:0] acc_q, acc_nxt, data_q;
   logic             slot_ws_q, word_ws_q, push_q;

   assign dly     = just ? PW'(0) : PW'(1);
   assign wlen    = PW'(width_bits(word_w_e'(wsel)));
   assign acc_nxt = {acc_q[MAX_W-2:0], evt.sd};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rpos_q    <= '1;
         rcnt_q    <= '0;
         acc_q     <= '0;
         data_q    <= '0;
         slot_ws_q <= 1'b0;
         word_ws_q <= 1'b0;
         push_q    <= 1'b0;
      end else if (!run) begin
         rpos_q    <= '1;
         rcnt_q    <= '0;
         acc_q     <= '0;
         slot_ws_q <= 1'b0;
         word_ws_q <= 1'b0;
         push_q    <= 1'b0;
      end else begin
         push_q <= 1'b0;
         if (evt.fall) begin
            if (evt.slot_start) begin
               rpos_q    <= '0;
               slot_ws_q <= evt.ws;
            end else if (rpos_q != '1) begin
               rpos_q <= rpos_q + 1'b1;
            end
         end
         if (evt.rise) begin
            if (rpos_q == dly) begin
               acc_q     <= {{(MAX_W-1){1'b0}}, evt.sd};
               rcnt_q    <= PW'(1);
               word_ws_q <= slot_ws_q;
            end else if (rcnt_q != '0) begin
               acc_q  <= acc_nxt;
               rcnt_q <= rcnt_q + 1'b1;
               if (rcnt_q + 1'b1 == wlen) begin
                  rcnt_q <= '0;
                  if (!mono || word_ws_q) begin
                     push_q <= 1'b1;
                     data_q <= acc_nxt;
                  end
               end
            end
         end
      end
   end

   assign rx_push = push_q;
   assign rx_data = data_q;

   // R2
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !rx_push);

   // R4
   rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> ((rx_data >> width_bits(word_w_e'($past(wsel)))) == '0));

endmodule

// File: rtl/i2s_engine.sv
module i2s_engine
   import i2s_eng_pkg::*;
#(
   parameter int MAX_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tx_en,
   input  logic             rx_en,
   input  logic             mute,
   input  logic [1:0]       word_sel,
   input  logic             msb_just,
   input  logic             mono,
   input  logic             slave,
   input  logic             bclk_tick,
   input  logic             bclk_in,
   input  logic             ws_in,
   input  logic             sd_in,
   output logic             bclk_out,
   output logic             ws_out,
   output logic             bclk_oe,
   output logic             sd_out,
   input  logic             tx_valid,
   input  logic [MAX_W-1:0] tx_data,
   output logic             tx_pop,
   output logic             tx_underflow,
   output logic             rx_push,
   output logic [MAX_W-1:0] rx_data,
   output logic             tx_right,
   output logic             tx_busy
);

   // slot length equals MAX_W, which must hold the widest word code
   if (MAX_W < 32 || (MAX_W & (MAX_W - 1)) != 0) begin : g_bad_width
      $error("MAX_W must be a power of two of at least 32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   bus_evt_t evt;

   i2s_eng_clk #(.MAX_W(MAX_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .slave    (slave),
      .tick     (bclk_tick),
      .bclk_in  (bclk_in),
      .ws_in    (ws_in),
      .sd_in    (sd_in),
      .bclk_out (bclk_out),
      .ws_out   (ws_out),
      .evt      (evt)
   );

   i2s_eng_tx #(.MAX_W(MAX_W)) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (en & tx_en),
      .fall         (evt.fall),
      .slot_start   (evt.slot_start),
      .ws           (evt.ws),
      .mute         (mute),
      .just         (msb_just),
      .wsel         (word_sel),
      .tx_valid     (tx_valid),
      .tx_data      (tx_data),
      .tx_pop       (tx_pop),
      .tx_underflow (tx_underflow),
      .sd_out       (sd_out),
      .tx_right     (tx_right),
      .tx_busy      (tx_busy)
   );

   i2s_eng_rx #(.MAX_W(MAX_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en & rx_en),
      .evt     (evt),
      .just    (msb_just),
      .mono    (mono),
      .wsel    (word_sel),
      .rx_push (rx_push),
      .rx_data (rx_data)
   );

   assign bclk_oe = ~slave;

endmodule

// File: tb/i2s_engine_tb_top.sv
module i2s_engine_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SL_HALF    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        en = 0, tx_en = 0, rx_en = 0, mute = 0, msb_just = 0, mono = 0, slave = 0;
   logic [1:0]  word_sel = 2'd0;
   logic        bclk_tick = 1'b1, bclk_in = 1'b0, ws_in = 1'b0;
   logic        tx_valid = 1'b0;
   logic [31:0] tx_data = 32'h0;
   wire         sd_in;
   logic        bclk_out, ws_out, bclk_oe, sd_out, tx_pop, tx_underflow, rx_push, tx_right, tx_busy;
   logic [31:0] rx_data;

   assign sd_in = sd_out;  // loopback

   i2s_engine dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .tx_en(tx_en), .rx_en(rx_en), .mute(mute),
      .word_sel(word_sel), .msb_just(msb_just), .mono(mono), .slave(slave),
      .bclk_tick(bclk_tick), .bclk_in(bclk_in), .ws_in(ws_in), .sd_in(sd_in),
      .bclk_out(bclk_out), .ws_out(ws_out), .bclk_oe(bclk_oe), .sd_out(sd_out),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .tx_underflow(tx_underflow),
      .rx_push(rx_push), .rx_data(rx_data), .tx_right(tx_right), .tx_busy(tx_busy)
   );

   int errors = 0;
   int checks = 0;

   task automatic check(input bit ok, input string req, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s", req, what);
      end
   endtask

   function automatic logic [31:0] wmask(input logic [1:0] code);
      int w = 8 * (int'(code) + 1);
      return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
   endfunction

   // ---------------- scoreboard ----------------
   logic [31:0] txq[$];
   logic [31:0] expq[$];
   logic [31:0] exp_w;
   bit pend_pop, chk_load, load_was_pop, chan, sb_on;
   int n_push, n_match, n_pop, n_unf, ones;

   always @(negedge clk) begin
      if (chk_load) begin
         check(tx_right == chan, "R8",
               $sformatf("tx_right actual=%0b expected=%0b", tx_right, chan));
         check(tx_busy == load_was_pop, "R9",
               $sformatf("tx_busy actual=%0b expected=%0b", tx_busy, load_was_pop));
         chk_load = 0;
      end
      if (pend_pop) begin
         txq.delete(0);
         pend_pop = 0;
      end
      tx_valid = (txq.size() != 0);
      tx_data  = tx_valid ? txq[0] : 32'h0;
      #1;
      if (tx_pop || tx_underflow) begin
         chan = !chan;
         chk_load = 1;
         load_was_pop = tx_pop;
         if (tx_pop) begin pend_pop = 1; n_pop++; end
         else n_unf++;
         if (!mono || chan)
            expq.push_back((tx_pop && !mute) ? (tx_data & wmask(word_sel)) : 32'h0);
      end
      if (sd_out) ones++;
      if (rx_push) begin
         n_push++;
         if (sb_on) begin
            if (expq.size() == 0) begin
               check(1'b0, "R4", $sformatf("rx word actual=%h expected=none", rx_data));
            end else begin
               exp_w = expq.pop_front();
               check(rx_data == exp_w, "R4",
                     $sformatf("rx word actual=%h expected=%h", rx_data, exp_w));
               if (rx_data == exp_w) n_match++;
            end
         end
      end
   end

   // ---------------- bus monitor (master) ----------------
   logic prev_b = 1'b0, lastws = 1'b0;
   int   pos, first_one, first_ws, last_len, rises;

   always @(negedge clk) begin
      if (bclk_out && !prev_b) begin
         rises++;
         if (ws_out != lastws) begin
            last_len = pos + 1;
            pos = 0;
            lastws = ws_out;
         end else begin
            pos++;
         end
         if (sd_out && first_one < 0) begin
            first_one = pos;
            first_ws  = ws_out;
         end
      end
      prev_b = bclk_out;
   end

   // ---------------- slave clock source ----------------
   bit sgen;
   int scnt, sbits;

   always @(negedge clk) begin
      if (sgen) begin
         scnt++;
         if (scnt == SL_HALF) begin
            scnt = 0;
            if (bclk_in) begin
               bclk_in = 1'b0;
               sbits++;
               if (sbits == 32) begin
                  sbits = 0;
                  ws_in = !ws_in;
               end
            end else begin
               bclk_in = 1'b1;
            end
         end
      end
   end

   // ---------------- phase control ----------------
   task automatic stop_all();
      en = 0;
      sgen = 0;
      repeat (4) @(negedge clk);
      txq.delete();
      expq.delete();
      pend_pop = 0; chk_load = 0; chan = 0;
      n_push = 0; n_match = 0; n_pop = 0; n_unf = 0; ones = 0;
      pos = -1; lastws = 0; first_one = -1; first_ws = 0; last_len = 0; rises = 0;
      scnt = 0; sbits = 0; bclk_in = 0; ws_in = 0;
   endtask

   task automatic run_phase(input bit sl, input logic [1:0] wc, input bit js, input bit mo,
                            input bit mu, input bit te, input bit re, input bit sb, input int cyc);
      slave = sl; word_sel = wc; msb_just = js; mono = mo; mute = mu;
      tx_en = te; rx_en = re; sb_on = sb;
      sgen = sl;
      en = 1;
      repeat (cyc) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      check(!bclk_out && !ws_out && !sd_out && !tx_busy && !tx_pop, "R1",
            $sformatf("reset outputs actual=%b%b%b%b%b expected=00000",
                      bclk_out, ws_out, sd_out, tx_busy, tx_pop));

      // R1: global enable low
      stop_all();
      txq = '{32'h1111_2222};
      tx_en = 1; rx_en = 1; slave = 0;
      repeat (200) @(negedge clk);
      check(n_pop == 0 && n_push == 0 && n_unf == 0, "R1",
            $sformatf("activity actual=%0d/%0d/%0d expected=0/0/0", n_pop, n_push, n_unf));
      check(rises == 0 && !ws_out && ones == 0, "R1",
            $sformatf("bus activity rises=%0d ones=%0d expected=0", rises, ones));

      // R4 R10 R7 R9: standard framing, 16 bit, stereo, queue drains
      stop_all();
      txq = '{32'h1234_ABCD, 32'h8001_7FFE, 32'hFFFF_0000, 32'h0000_5A5A};
      run_phase(0, 2'd1, 0, 0, 0, 1, 1, 1, 700);
      check(n_match >= 4, "R4", $sformatf("matched words actual=%0d expected>=4", n_match));
      check(n_unf > 0, "R10", $sformatf("underflows actual=%0d expected>0", n_unf));
      check(last_len == 32, "R7", $sformatf("slot length actual=%0d expected=32", last_len));
      check(bclk_oe == 1'b1, "R7", $sformatf("bclk_oe actual=%0b expected=1", bclk_oe));
      check(tx_busy == 1'b0, "R9", $sformatf("busy after drain actual=%0b expected=0", tx_busy));

      // R5: justified framing, MSB on first bit clock of the right slot
      stop_all();
      txq = '{32'h0000_0080, 32'h0000_0000};
      run_phase(0, 2'd0, 1, 0, 0, 1, 1, 1, 300);
      check(first_one == 0 && first_ws == 1, "R5",
            $sformatf("justified MSB pos actual=%0d ws=%0d expected=0 ws=1", first_one, first_ws));
      check(n_match >= 2, "R5", $sformatf("matched words actual=%0d expected>=2", n_match));

      // R5: standard framing, MSB one bit clock later
      stop_all();
      txq = '{32'h0000_0080, 32'h0000_0000};
      run_phase(0, 2'd0, 0, 0, 0, 1, 1, 1, 300);
      check(first_one == 1 && first_ws == 1, "R5",
            $sformatf("standard MSB pos actual=%0d ws=%0d expected=1 ws=1", first_one, first_ws));

      // R4 R5: 32 bit standard framing, LSB crosses into the next slot
      stop_all();
      txq = '{32'hDEAD_BEEF, 32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF};
      run_phase(0, 2'd3, 0, 0, 0, 1, 1, 1, 500);
      check(n_match >= 4, "R4", $sformatf("32-bit matched actual=%0d expected>=4", n_match));

      // R6: mono, 24 bit justified
      stop_all();
      txq = '{32'hAA12_3456, 32'h55AB_CDEF, 32'hC3FE_DCBA, 32'h3C00_0001};
      run_phase(0, 2'd2, 1, 1, 0, 1, 1, 1, 500);
      check(n_match >= 2, "R6", $sformatf("mono matched actual=%0d expected>=2", n_match));
      check(2 * n_push <= n_pop + n_unf + 1, "R6",
            $sformatf("mono pushes actual=%0d loads=%0d expected<=half", n_push, n_pop + n_unf));

      // R3: mute
      stop_all();
      txq = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
      run_phase(0, 2'd3, 1, 0, 1, 1, 1, 1, 400);
      check(ones == 0, "R3", $sformatf("muted high bits actual=%0d expected=0", ones));
      check(n_pop == 3, "R3", $sformatf("muted pops actual=%0d expected=3", n_pop));

      // R2: receive disabled
      stop_all();
      txq = '{32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h1234_5678};
      run_phase(0, 2'd3, 1, 0, 0, 1, 0, 0, 400);
      check(n_pop == 3 && n_push == 0, "R2",
            $sformatf("rx off pops/pushes actual=%0d/%0d expected=3/0", n_pop, n_push));

      // R2: transmit disabled
      stop_all();
      txq = '{32'hFFFF_FFFF, 32'hFFFF_FFFF};
      run_phase(0, 2'd3, 1, 0, 0, 0, 1, 0, 400);
      check(n_pop == 0 && n_unf == 0 && ones == 0, "R2",
            $sformatf("tx off pops/unf/ones actual=%0d/%0d/%0d expected=0/0/0", n_pop, n_unf, ones));

      // R7: slave mode on external clock
      stop_all();
      txq = '{32'hCAFE_F00D, 32'h1357_9BDF, 32'h2468_ACE0};
      run_phase(1, 2'd3, 1, 0, 0, 1, 1, 1, 2200);
      check(n_match >= 3, "R7", $sformatf("slave matched actual=%0d expected>=3", n_match));
      check(bclk_oe == 1'b0 && bclk_out == 1'b0, "R7",
            $sformatf("slave oe/bclk actual=%0b/%0b expected=0/0", bclk_oe, bclk_out));

      stop_all();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule